// File: doc/BRIEF.md
# Multiplexed ADC Register Interface

This block is the bus-facing register front end of a sixteen-channel, 8-bit analog-to-digital converter. A host reads and writes two 16-bit registers at byte addresses 0 and 2 over a simple single-cycle bus. Address 0 holds the conversion result and a completion flag. Address 2 takes a channel number and a start request on writes. On reads it returns the selected channel and a set of live threshold-comparator flags for the six highest channels.

The converter itself is replaced by digital inputs: one 8-bit sample lane per channel and one comparator bit per high channel. A word write with the start bit set arms a fixed-latency conversion. When the latency runs out, the block samples the lane of the selected channel and sets the completion flag in the same cycle. Byte writes are discarded. Byte reads return the upper half of the addressed register. Any word write to the control register clears the completion flag.

Top module: `adc_regif`

## Requirements
- R1: A word read of address 0 returns the completion flag in bit 15, zeros in bits 14..8 and the unsigned result in bits 7..0.
- R2: A word read of address 2 returns the comparator flags in bits 15..10 (bit 15 for channel 15, down to bit 10 for channel 10), the channel selector in bits 9..6 and zeros in bits 5..0.
- R3: A word write to address 2 loads bits 3..0 into the channel selector (also driven on `chan_sel`) and treats bit 8 as the start request. Bit 7 and all other bits have no effect.
- R4: A byte write (`bus_word` low) to any address changes no register: selector, flag and result keep their values.
- R5: A byte read returns bits 15..8 of the addressed register on `bus_rdata[7:0]`, with `bus_rdata[15:8]` zero.
- R6: After reset the completion flag is 0, the result is 0 and channel 0 is selected.
- R7: Every word write to address 2 clears the completion flag on the write's clock edge. A word write to address 2 without the start bit also cancels any conversion in progress, so that conversion never completes.
- R8: A conversion started by a write at clock edge k completes at edge k+CONV_LAT. At that edge the lane of the selected channel is loaded into the result and the flag is set together. Before that edge the result keeps its previous value.
- R9: A start request during an active conversion restarts the latency from the new write and uses the newly written channel.
- R10: Word writes to address 0 or to any undefined address have no effect. Reads of undefined addresses return zero.
- R11: `bus_rdata` is zero whenever no read access is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| ch_sample | input | 16*SAMPLE_W | Converter sample lanes, channel c at bits c*SAMPLE_W upward |
| cmp_flags | input | NUM_CMP | Threshold flags; the top bit belongs to channel 15 |
| chan_sel | output | CH_W | Current channel selector |

## Verification
The bench builds the block with CONV_LAT = 4 and ADDR_W = 3. The short latency lets every channel be converted several times under different ignored-bit patterns and sample sets in a few hundred cycles. It also keeps restarts and cancellations inside a window the bench can check edge by edge. With the narrow address, all eight byte addresses can be swept, so every undefined address is written and read in both widths. Expected samples and status words are computed arithmetically from the channel number and a seed.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;

   localparam int unsigned BUS_W = 16;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_RESULT = 2'd1,
      SEL_CTRL   = 2'd2
   } reg_sel_e;

endpackage

// File: rtl/adc_regif_decode.sv
module adc_regif_decode
   import adc_regif_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned RESULT_OFS = 0,
   parameter int unsigned CTRL_OFS   = 2
) (
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic              word_i,
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_e          rd_sel_o,
   output logic              rd_byte_o,
   output logic              ctrl_wr_o
);

   localparam logic [ADDR_W-1:0] RES_A  = ADDR_W'(RESULT_OFS);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("adc_regif_decode: ADDR_W must be at least 2");
   end
   if (RESULT_OFS == CTRL_OFS) begin : g_bad_ofs
      $error("adc_regif_decode: register offsets must differ");
   end

   logic hit_res, hit_ctrl;

   assign hit_res  = (addr_i == RES_A);
   assign hit_ctrl = (addr_i == CTRL_A);

   always_comb begin
      rd_sel_o = SEL_NONE;
      if (sel_i && !wr_i) begin
         if (hit_res)
            rd_sel_o = SEL_RESULT;
         else if (hit_ctrl)
            rd_sel_o = SEL_CTRL;
      end
   end

   assign rd_byte_o = !word_i;
   // Only a full-width write reaches the control register
   assign ctrl_wr_o = sel_i && wr_i && word_i && hit_ctrl;

endmodule

// File: rtl/adc_regif_smux.sv
module adc_regif_smux #(
   parameter int unsigned CH_W     = 4,
   parameter int unsigned SAMPLE_W = 8
) (
   input  logic [(2**CH_W)*SAMPLE_W-1:0] lanes_i,
   input  logic [CH_W-1:0]               sel_i,
   output logic [SAMPLE_W-1:0]           sample_o
);

   localparam int unsigned NUM_CH = 2**CH_W;

   logic [SAMPLE_W-1:0] lane_a [NUM_CH];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
      assign lane_a[g] = lanes_i[g*SAMPLE_W +: SAMPLE_W];
   end

   assign sample_o = lane_a[sel_i];

endmodule

// File: rtl/adc_regif_seq.sv
module adc_regif_seq #(
   parameter int unsigned CH_W     = 4,
   parameter int unsigned SAMPLE_W = 8,
   parameter int unsigned CONV_LAT = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctrl_wr_i,
   input  logic                start_i,
   input  logic [CH_W-1:0]     chan_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   output logic [CH_W-1:0]     chan_o,
   output logic                done_o,
   output logic [SAMPLE_W-1:0] result_o
);

   localparam int unsigned CNT_W = (CONV_LAT > 2) ? $clog2(CONV_LAT) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_LAT - 1);

   if (CONV_LAT < 2 || CONV_LAT > 25) begin : g_bad_lat
      $error("adc_regif_seq: CONV_LAT must lie in 2..25");
   end

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         cnt_q    <= '0;
         chan_o   <= '0;
         done_o   <= 1'b0;
         result_o <= '0;
      end else if (ctrl_wr_i) begin
         chan_o <= chan_i;
         done_o <= 1'b0;
         busy_q <= start_i;
         cnt_q  <= CNT_LOAD;
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            busy_q   <= 1'b0;
            done_o   <= 1'b1;
            result_o <= sample_i;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   // R7
   ctrl_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr_i |=> !done_o);

   // R8
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(done_o) |-> $stable(result_o));

   // R8
   done_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(busy_q));

   // R8
   busy_ends_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !ctrl_wr_i) |=> (busy_q || done_o));

endmodule

// File: rtl/adc_regif.sv
module adc_regif
   import adc_regif_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned CH_W     = 4,
   parameter int unsigned SAMPLE_W = 8,
   parameter int unsigned NUM_CMP  = 6,
   parameter int unsigned CONV_LAT = 20
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           bus_sel,
   input  logic                           bus_wr,
   input  logic                           bus_word,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic [15:0]                    bus_wdata,
   output logic [15:0]                    bus_rdata,
   input  logic [(2**CH_W)*SAMPLE_W-1:0]  ch_sample,
   input  logic [NUM_CMP-1:0]             cmp_flags,
   output logic [CH_W-1:0]                chan_sel
);

   localparam int unsigned START_BIT = 8;
   localparam int unsigned STAT_PAD  = BUS_W - NUM_CMP - CH_W;
   localparam int unsigned RES_PAD   = BUS_W - 1 - SAMPLE_W;

   if (SAMPLE_W < 1 || SAMPLE_W > 8) begin : g_bad_sw
      $error("adc_regif: SAMPLE_W must lie in 1..8");
   end
   if (CH_W < 1 || CH_W > 7) begin : g_bad_cw
      $error("adc_regif: CH_W must lie in 1..7");
   end
   if (NUM_CMP < 1 || STAT_PAD < 1) begin : g_bad_cmp
      $error("adc_regif: NUM_CMP and CH_W do not fit the status word");
   end

   reg_sel_e            rd_sel;
   logic                rd_byte;
   logic                ctrl_wr;
   logic                done;
   logic [SAMPLE_W-1:0] result;
   logic [SAMPLE_W-1:0] sample;
   logic [15:0]         res_word;
   logic [15:0]         stat_word;
   logic [15:0]         word_v;
   logic                unused_wbits;

   assign unused_wbits = ^{bus_wdata[15:START_BIT+1], bus_wdata[START_BIT-1:CH_W]};

   adc_regif_decode #(
      .ADDR_W     (ADDR_W),
      .RESULT_OFS (0),
      .CTRL_OFS   (2)
   ) i_decode (
      .sel_i     (bus_sel),
      .wr_i      (bus_wr),
      .word_i    (bus_word),
      .addr_i    (bus_addr),
      .rd_sel_o  (rd_sel),
      .rd_byte_o (rd_byte),
      .ctrl_wr_o (ctrl_wr)
   );

   adc_regif_smux #(
      .CH_W     (CH_W),
      .SAMPLE_W (SAMPLE_W)
   ) i_smux (
      .lanes_i  (ch_sample),
      .sel_i    (chan_sel),
      .sample_o (sample)
   );

   adc_regif_seq #(
      .CH_W     (CH_W),
      .SAMPLE_W (SAMPLE_W),
      .CONV_LAT (CONV_LAT)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr_i (ctrl_wr),
      .start_i   (bus_wdata[START_BIT]),
      .chan_i    (bus_wdata[CH_W-1:0]),
      .sample_i  (sample),
      .chan_o    (chan_sel),
      .done_o    (done),
      .result_o  (result)
   );

   assign res_word  = {done, {RES_PAD{1'b0}}, result};
   assign stat_word = {cmp_flags, chan_sel, {STAT_PAD{1'b0}}};

   always_comb begin
      unique case (rd_sel)
         SEL_RESULT: word_v = res_word;
         SEL_CTRL:   word_v = stat_word;
         default:    word_v = '0;
      endcase
   end

   assign bus_rdata = rd_byte ? {8'h00, word_v[15:8]} : word_v;

   // R4
   byte_wr_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !bus_word) |=> $stable(chan_sel));

   // R4
   byte_wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !bus_word && done) |=> done);

   // R11
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel || bus_wr) |-> (bus_rdata == 16'h0000));

endmodule

// File: tb/test_adc_regif.sv
module test_adc_regif;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned LAT   = 4;
   localparam int unsigned AW    = 3;
   localparam int unsigned NCH   = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_word = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [15:0]   bus_wdata = '0;
   logic [15:0]   bus_rdata;
   logic [NCH*8-1:0] ch_sample = '0;
   logic [5:0]    cmp_flags = '0;
   logic [3:0]    chan_sel;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_regif #(
      .ADDR_W   (AW),
      .CH_W     (4),
      .SAMPLE_W (8),
      .NUM_CMP  (6),
      .CONV_LAT (LAT)
   ) i_adc_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_word  (bus_word),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ch_sample (ch_sample),
      .cmp_flags (cmp_flags),
      .chan_sel  (chan_sel)
   );

   function automatic logic [7:0] samp(int c, int s);
      return 8'((c * 37 + s * 73 + 11) % 256);
   endfunction

   task automatic load_samples(int s);
      for (int c = 0; c < NCH; c++) ch_sample[c*8 +: 8] = samp(c, s);
   endtask

   task automatic check(string req, logic [15:0] got, logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [15:0] d, logic w);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_word = w; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, logic w, string req, logic [15:0] exp);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_word = w; bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
      bus_sel = 1'b0;
   endtask

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      logic [7:0]  prev;
      logic [15:0] d;
      logic [3:0]  ch;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R6 reset state
      rd(0, 1'b1, "R6 result after reset", 16'h0000);
      rd(2, 1'b1, "R6 status after reset", 16'h0000);
      check("R6 chan_sel after reset", {12'h0, chan_sel}, 16'h0000);

      // R1 R2 R3 R7 R8 sweep all channels and ignored-bit patterns
      prev = 8'h00;
      for (int s = 0; s < 3; s++) begin
         for (int c = 0; c < NCH; c++) begin
            load_samples(s);
            cmp_flags = 6'((c * 5 + s * 3) % 64);
            d = 16'h0100 | 16'(c);
            if (s == 1) d = d | 16'h0080;
            if (s == 2) d = d | 16'hFE70;
            wr(2, d, 1'b1);
            check("R3 chan_sel", {12'h0, chan_sel}, 16'(c));
            rd(2, 1'b1, "R2 status word", {cmp_flags, 4'(c), 6'b0});
            rd(0, 1'b1, "R7 flag cleared by write", {8'h00, prev});
            cyc(LAT - 1);
            rd(0, 1'b1, "R8 not yet complete", {8'h00, prev});
            cyc(1);
            prev = samp(c, s);
            rd(0, 1'b1, "R1 R8 completed result", {8'h80, prev});
         end
      end

      // R5 byte reads
      rd(0, 1'b0, "R5 byte read result", 16'h0080);
      rd(2, 1'b0, "R5 byte read status", {8'h00, cmp_flags, chan_sel[3:2]});

      // R4 byte writes dropped at every address
      ch = chan_sel;
      for (int a = 0; a < 8; a++) wr(AW'(a), 16'h0105, 1'b0);
      cyc(2 * LAT);
      check("R4 chan after byte writes", {12'h0, chan_sel}, {12'h0, ch});
      rd(0, 1'b1, "R4 result/flag after byte writes", {8'h80, prev});

      // R10 writes to address 0 and undefined addresses, reads of undefined
      for (int a = 0; a < 8; a++) begin
         if (a != 2) wr(AW'(a), 16'h0109, 1'b1);
      end
      cyc(2 * LAT);
      check("R10 chan after stray writes", {12'h0, chan_sel}, {12'h0, ch});
      rd(0, 1'b1, "R10 result after stray writes", {8'h80, prev});
      for (int a = 0; a < 8; a++) begin
         if (a != 0 && a != 2) begin
            rd(AW'(a), 1'b1, "R10 undefined word read", 16'h0000);
            rd(AW'(a), 1'b0, "R10 undefined byte read", 16'h0000);
         end
      end

      // R7 write without start clears flag; cancels running conversion
      load_samples(5);
      wr(2, 16'h0087, 1'b1);
      rd(0, 1'b1, "R7 clear without start", {8'h00, prev});
      check("R7 chan loaded without start", {12'h0, chan_sel}, 16'h0007);
      wr(2, 16'h0102, 1'b1);
      cyc(1);
      wr(2, 16'h0005, 1'b1);
      cyc(2 * LAT);
      rd(0, 1'b1, "R7 cancelled conversion", {8'h00, prev});

      // R9 restart with a new channel
      wr(2, 16'h0103, 1'b1);
      cyc(1);
      load_samples(6);
      wr(2, 16'h0109, 1'b1);
      cyc(LAT - 1);
      rd(0, 1'b1, "R9 restart not yet complete", {8'h00, prev});
      cyc(1);
      rd(0, 1'b1, "R9 restart result", {8'h80, samp(9, 6)});

      // R11 no read presented
      bus_sel = 1'b0; bus_wr = 1'b0; bus_word = 1'b1; bus_addr = 0;
      #1;
      check("R11 rdata idle", bus_rdata, 16'h0000);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_word = 1'b0; bus_addr = 2;
      #1;
      check("R11 rdata during write", bus_rdata, 16'h0000);
      bus_sel = 1'b0; bus_wr = 1'b0;

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule